// File: doc/BRIEF.md
# Pseudo-Random Byte Streamer

This block produces a stream of 8-bit pseudo-random values from a linear feedback shift register and hands each value to a serial transmitter over a valid/ready byte interface. A host on the far side of the serial link can then show the values as a live trace. The register state is the byte on offer. It steps to its next state only in a cycle where the transmitter accepts the byte. While the transmitter is busy, no value is lost or sent twice.

Two feedback forms share one polynomial, x^8 + x^6 + x^5 + x^4 + 1. In the first form, several stages are combined by XOR and the result is shifted into the low end. In the second form, the top bit is folded back into the register at every tap position. Both forms visit all 255 nonzero states before they repeat, but in a different order. A select input chooses the form. The block samples that input only while it is held in reset or disabled.

Top module: `prng_byte_streamer`

## Requirements
- R1: During reset and in the first cycle after it, outData reads 0x01 (the seed). With enable low, outValid is 0.
- R2: outValid is 1 exactly in the cycles where enable is 1.
- R3: With latched form 0 (many-to-one), an accepted byte d is followed by {d[6:0], d[7]^d[5]^d[4]^d[3]}. From the seed, the fifth byte is 0x11.
- R4: With latched form 1 (one-to-many), an accepted byte d is followed by {d[6:0],1'b0} XOR (d[7] ? 0x71 : 0x00). From the seed, the ninth byte is 0x71.
- R5: The register advances exactly once for each clock edge at which outValid and outReady are both 1. In every other cycle, outData holds its value.
- R6: In each form, starting from the seed, 255 accepted bytes return outData to 0x01. The 255 bytes seen along the way are all different.
- R7: The form is taken from topoSel at clock edges where rstN is 0 or enable is 0. A change of topoSel while enable is 1 has no effect on the bytes produced.
- R8: The 255-byte sequences of the two forms, each taken from the seed, differ.
- R9: outData is never 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Offer bytes to the transmitter when 1 |
| topoSel | input | 1 | Feedback form: 0 many-to-one, 1 one-to-many |
| outReady | input | 1 | Transmitter accepts the offered byte |
| outValid | output | 1 | A byte is on offer |
| outData | output | 8 | Current register state, the offered byte |

## Verification
Each form is run through a whole period with the transmitter always ready. This shows the stepping rule, the return to the seed, and the absence of repeats or zero, and it separates the two forms by comparing their sequences. A random ready pattern and stretches with enable low check that stepping happens only on a handshake. Changing the select both while streaming and while disabled shows the difference between an ignored change and a latched one. A behavioural reference is compared with the outputs on every clock, so any skipped, repeated or wrong byte is caught in the cycle where it appears.

// File: rtl/prng_stream_pkg.sv
package prng_stream_pkg;

  typedef enum logic {
    TOPO_MANY_TO_ONE = 1'b0,
    TOPO_ONE_TO_MANY = 1'b1
  } topo_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  advance;
    topo_e topo;
  } dp_ctrl_t;

endpackage

// File: rtl/prng_stream_ctrl.sv
module prng_stream_ctrl
  import prng_stream_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     topoSel,
  input  logic     outReady,
  output logic     outValid,
  output dp_ctrl_t dpCtrl
);

  topo_e topoQ;

  // form is captured only while held in reset or disabled
  always_ff @(posedge clk) begin
    if (!rstN || !enable) topoQ <= topo_e'(topoSel);
  end

  assign outValid       = enable;
  assign dpCtrl.advance = enable & outReady;
  assign dpCtrl.topo    = topoQ;

  // R7: latched form frozen while streaming
  p_topo_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> $stable(topoQ));

endmodule

// File: rtl/prng_stream_datapath.sv
module prng_stream_datapath
  import prng_stream_pkg::*;
#(
  parameter int              W        = 8,
  parameter logic [W-1:0]    FIB_TAPS = 8'hB8,
  parameter logic [W-1:0]    GAL_TAPS = 8'h71,
  parameter logic [W-1:0]    SEED     = 8'h01
) (
  input  logic         clk,
  input  logic         rstN,
  input  dp_ctrl_t     dpCtrl,
  output logic [W-1:0] state
);

  logic [W-1:0] nextFib;
  logic [W-1:0] nextGal;
  logic [W-1:0] nextSel;
  logic [W-1:0] nextSafe;

  // many-to-one: parity of tapped stages enters stage 0
  assign nextFib = {state[W-2:0], ^(state & FIB_TAPS)};

  // one-to-many: top bit folded into every tap position
  assign nextGal[0] = state[W-1] & GAL_TAPS[0];
  for (genvar i = 1; i < W; i++) begin : g_gal
    assign nextGal[i] = state[i-1] ^ (state[W-1] & GAL_TAPS[i]);
  end

  assign nextSel  = (dpCtrl.topo == TOPO_ONE_TO_MANY) ? nextGal : nextFib;
  assign nextSafe = (nextSel == '0) ? SEED : nextSel;

  always_ff @(posedge clk) begin
    if (!rstN)               state <= SEED;
    else if (dpCtrl.advance) state <= nextSafe;
  end

  // R5: no handshake, no step
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.advance |=> $stable(state));

  // R9: lock-up state never seen
  p_nonzero_r9: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);

  // R4: one-to-many step relation
  p_step_gal_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.advance && dpCtrl.topo == TOPO_ONE_TO_MANY) |=>
      (state == ({$past(state[W-2:0]), 1'b0} ^ ({W{$past(state[W-1])}} & GAL_TAPS))));

endmodule

// File: rtl/prng_byte_streamer.sv
module prng_byte_streamer
  import prng_stream_pkg::*;
#(
  parameter int           W        = 8,
  parameter logic [W-1:0] FIB_TAPS = 8'hB8,
  parameter logic [W-1:0] GAL_TAPS = 8'h71,
  parameter logic [W-1:0] SEED     = 8'h01
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         topoSel,
  input  logic         outReady,
  output logic         outValid,
  output logic [W-1:0] outData
);

  dp_ctrl_t dpCtrl;

  prng_stream_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .topoSel  (topoSel),
    .outReady (outReady),
    .outValid (outValid),
    .dpCtrl   (dpCtrl)
  );

  prng_stream_datapath #(
    .W        (W),
    .FIB_TAPS (FIB_TAPS),
    .GAL_TAPS (GAL_TAPS),
    .SEED     (SEED)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .dpCtrl (dpCtrl),
    .state  (outData)
  );

endmodule

// File: tb/prng_byte_streamer_tb.sv
`timescale 1ns/1ps
module prng_byte_streamer_tb_top;

  logic       clk      = 1'b0;
  logic       rstN     = 1'b0;
  logic       enable   = 1'b0;
  logic       topoSel  = 1'b0;
  logic       outReady = 1'b0;
  logic       outValid;
  logic [7:0] outData;

  int compared   = 0;
  int mismatched = 0;
  int cycles     = 0;
  bit done       = 1'b0;

  int modelState = 1;
  bit modelTopo  = 1'b0;

  int seq0 [255];
  int seq1 [255];

  always #2.5 clk = ~clk;

  prng_byte_streamer dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .topoSel  (topoSel),
    .outReady (outReady),
    .outValid (outValid),
    .outData  (outData)
  );

  function automatic int stepModel(int s, bit t);
    int n;
    n = (s * 2) % 256;
    if (!t) n = n + ($countones(s & 'hB8) % 2);
    else if (s >= 128) n = n ^ 'h71;
    return n;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // reference model and per-cycle comparison
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      modelState = 1;
      modelTopo  = topoSel;
    end else begin
      if (enable && outReady) modelState = stepModel(modelState, modelTopo);
      if (!enable) modelTopo = topoSel;
    end
    #1;
    if (!done) begin
      check("R2 valid follows enable", {31'd0, outValid}, {31'd0, enable});
      check("R3 R4 R5 R7 stream vs model", {24'd0, outData}, modelState);
      if (rstN) check("R9 nonzero byte", {31'd0, outData != 8'd0}, 32'd1);
      if (cycles > 150000) begin
        mismatched++;
        $display("FAIL watchdog (all requirements) actual=%0d expected=<150000", cycles);
        finishRun();
      end
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(bit mode);
    enable = 1'b0; outReady = 1'b0; topoSel = mode; rstN = 1'b0;
    waitCyc(2);
    rstN = 1'b1;
    waitCyc(1);
  endtask

  task automatic runPeriod(bit mode);
    bit seen [256];
    int dupes = 0;
    int zeros = 0;
    for (int k = 0; k < 256; k++) seen[k] = 1'b0;
    restart(mode);
    enable = 1'b1; outReady = 1'b1;
    for (int i = 0; i < 255; i++) begin
      if (mode) seq1[i] = outData; else seq0[i] = outData;
      if (seen[outData]) dupes++;
      seen[outData] = 1'b1;
      if (outData == 8'd0) zeros++;
      @(negedge clk);
    end
    check("R6 back to seed after 255", {24'd0, outData}, 32'h01);
    check("R6 all bytes distinct", dupes, 0);
    check("R9 no zero in period", zeros, 0);
    enable = 1'b0; outReady = 1'b0;
  endtask

  initial begin
    int rec;
    int diff;
    int exp;
    waitCyc(4);
    check("R1 seed in reset", {24'd0, outData}, 32'h01);
    rstN = 1'b1;
    waitCyc(1);
    check("R1 seed after reset", {24'd0, outData}, 32'h01);
    check("R1 valid low when disabled", {31'd0, outValid}, 32'd0);

    runPeriod(1'b0);
    check("R3 fifth byte many-to-one", seq0[4], 32'h11);
    runPeriod(1'b1);
    check("R4 ninth byte one-to-many", seq1[8], 32'h71);
    diff = 0;
    for (int i = 0; i < 255; i++) if (seq0[i] != seq1[i]) diff++;
    check("R8 forms differ", {31'd0, diff > 0}, 32'd1);

    // R5: random backpressure and holds
    restart(1'b1);
    enable = 1'b1;
    for (int i = 0; i < 300; i++) begin
      outReady = $urandom % 2;
      @(negedge clk);
    end
    outReady = 1'b0;
    rec = outData;
    waitCyc(5);
    check("R5 hold without ready", {24'd0, outData}, rec);
    enable = 1'b0; outReady = 1'b1;
    waitCyc(5);
    check("R5 hold while disabled", {24'd0, outData}, rec);
    check("R2 valid low while disabled", {31'd0, outValid}, 32'd0);

    // R7: select change ignored while enabled, taken while disabled
    restart(1'b0);
    enable = 1'b1; outReady = 1'b1;
    waitCyc(10);
    topoSel = 1'b1;
    waitCyc(20);
    exp = 1;
    for (int i = 0; i < 30; i++) exp = stepModel(exp, 1'b0);
    check("R7 change while enabled ignored", {24'd0, outData}, exp);
    enable = 1'b0;
    waitCyc(2);
    enable = 1'b1;
    waitCyc(10);
    for (int i = 0; i < 10; i++) exp = stepModel(exp, 1'b1);
    check("R7 change while disabled taken", {24'd0, outData}, exp);
    enable = 1'b0; outReady = 1'b0;
    waitCyc(3);

    finishRun();
  end

endmodule